// File: doc/BRIEF.md
# Serial Port Interrupt Mask and Status Bank

This block gathers the interrupt sources of a serial port behind a small register port. Each source delivers a one-cycle event pulse, which is latched into a sticky status bit. Software clears a status bit by writing 1 to it. A separate mask decides which latched events may reach the single interrupt line.

The mask is never written directly. Software sets mask bits through a write-only enable register and clears them through a write-only disable register. It reads the resulting mask back from a read-only register, so a driver can change one source without a read-modify-write sequence. The interrupt output is a registered level: it is the OR over all sources of status AND mask.

The register port is single-cycle. A write takes effect on the clock edge where `wr_en` is high. Read data is combinational from `addr` while `rd_en` is high.

Top module: `irq_mask_bank`

## Requirements
- R1: A write to the enable register (address 2) sets every mask bit whose write-data bit is 1. Mask bits whose data bit is 0 keep their value.
- R2: A write to the disable register (address 3) clears every mask bit whose write-data bit is 1. Other mask bits keep their value.
- R3: A read of address 2 or 3, or of any address above 3, returns all zeros.
- R4: A read of address 1 returns the current mask in the same cycle: bit i is 1 when source i is enabled.
- R5: An event pulse on `evt_i[i]` sets status bit i at that clock edge, whatever the mask holds. The bit stays set until it is cleared. Source order: bit 0 transmit FIFO empty, bit 1 receive FIFO trigger level reached, bit 2 receive timeout. Address 0 reads the status.
- R6: A write to address 0 clears each status bit whose write-data bit is 1. Status bits whose data bit is 0 are unchanged.
- R7: When an event pulse and a write-1 clear hit the same status bit on the same edge, the bit ends up set.
- R8: `irq_o` is a registered level equal to the OR over i of (status[i] AND mask[i]). It shows the state of the previous cycle, so it rises on the second clock edge after the event that causes it.
- R9: While `rst_n` is low, the mask, the status and `irq_o` are all 0.
- R10: A write to the mask address (1) has no effect on the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW (3) | Register address |
| wdata | input | N_SRC (3) | Write data, one bit per source |
| rdata | output | N_SRC (3) | Read data, combinational; zero when `rd_en` is low |
| evt_i | input | N_SRC (3) | One-cycle event pulses from the sources |
| irq_o | output | 1 | Interrupt request level |

## Verification
A wrong mask or status bit shows at the ports in two ways. A read of address 1 or 0 returns the wrong value in the same cycle. After one more clock edge, `irq_o` takes the wrong level. The bench therefore reads both registers after every step and compares `irq_o` with the value predicted from the state one step earlier. A lost sticky bit, a clear that hits the wrong bit, or a lost event in a clear collision is thus caught within one or two cycles of the operation that caused it.

// File: rtl/irqmb_pkg.sv
package irqmb_pkg;
   // Register selector; offsets matter to software and to the bench
   typedef enum logic [1:0] {
      SEL_STAT = 2'd0,   // status, read / write-1-to-clear
      SEL_MASK = 2'd1,   // mask, read only
      SEL_SET  = 2'd2,   // mask enable, write only
      SEL_CLR  = 2'd3    // mask disable, write only
   } reg_sel_e;
endpackage

// File: rtl/irqmb_mask.sv
module irqmb_mask #(
   parameter int N_SRC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set_v,
   input  logic [N_SRC-1:0] clr_v,
   output logic [N_SRC-1:0] mask_o
);
   logic [N_SRC-1:0] mask_q;

   // clear has priority over set on the same bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= (mask_q | set_v) & ~clr_v;
   end

   assign mask_o = mask_q;

   a_r1_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      |(set_v & ~clr_v) |=> ((mask_o & $past(set_v & ~clr_v)) == $past(set_v & ~clr_v)));

   a_r2_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
      |clr_v |=> ((mask_o & $past(clr_v)) == '0));

   a_r1_hold_rest: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((mask_o ^ $past(mask_o)) & ~$past(set_v | clr_v)) == '0));
endmodule

// File: rtl/irqmb_status.sv
module irqmb_status #(
   parameter int N_SRC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] evt_i,
   input  logic [N_SRC-1:0] w1c_v,
   output logic [N_SRC-1:0] stat_o
);
   logic [N_SRC-1:0] stat_q;

   // a new event beats a clear landing on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~w1c_v) | evt_i;
   end

   assign stat_o = stat_q;

   // R5 and R7: an event always leaves its bit set, clear or not
   a_r5_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
      |evt_i |=> ((stat_o & $past(evt_i)) == $past(evt_i)));

   a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      |(w1c_v & ~evt_i) |=> ((stat_o & $past(w1c_v & ~evt_i)) == '0));

   a_r6_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((stat_o ^ $past(stat_o)) & ~$past(w1c_v | evt_i)) == '0));
endmodule

// File: rtl/irqmb_irq.sv
module irqmb_irq #(
   parameter int N_SRC   = 3,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] stat_i,
   input  logic [N_SRC-1:0] mask_i,
   output logic             irq_o
);
   logic pend;
   assign pend = |(stat_i & mask_i);

   generate
      if (REG_OUT) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= pend;
         end
         assign irq_o = irq_q;

         a_r8_one_cycle_lag: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_o == $past(|(stat_i & mask_i))));
      end else begin : g_comb
         assign irq_o = pend;
      end
   endgenerate
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int N_SRC   = 3,
   parameter int AW      = 3,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [AW-1:0]    addr,
   input  logic [N_SRC-1:0] wdata,
   output logic [N_SRC-1:0] rdata,
   input  logic [N_SRC-1:0] evt_i,
   output logic             irq_o
);
   import irqmb_pkg::*;

   localparam int SEL_W = 2;

   generate
      if (N_SRC < 1)    begin : g_bad_nsrc $error("N_SRC must be at least 1"); end
      if (AW < SEL_W)   begin : g_bad_aw   $error("AW too small for the register map"); end
   endgenerate

   // address decode: upper address bits must be zero for a hit
   logic     in_map;
   reg_sel_e sel;
   generate
      if (AW > SEL_W) begin : g_hi
         assign in_map = (addr[AW-1:SEL_W] == '0);
      end else begin : g_nohi
         assign in_map = 1'b1;
      end
   endgenerate
   assign sel = reg_sel_e'(addr[SEL_W-1:0]);

   logic [N_SRC-1:0] set_v, clr_v, w1c_v;
   always_comb begin
      set_v = '0;
      clr_v = '0;
      w1c_v = '0;
      if (wr_en && in_map) begin
         unique case (sel)
            SEL_SET:  set_v = wdata;
            SEL_CLR:  clr_v = wdata;
            SEL_STAT: w1c_v = wdata;
            default:  ;   // mask register ignores writes
         endcase
      end
   end

   logic [N_SRC-1:0] mask, stat;

   irqmb_mask #(.N_SRC(N_SRC)) u_mask (
      .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_v(clr_v), .mask_o(mask)
   );

   irqmb_status #(.N_SRC(N_SRC)) u_stat (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .w1c_v(w1c_v), .stat_o(stat)
   );

   irqmb_irq #(.N_SRC(N_SRC), .REG_OUT(REG_OUT)) u_irq (
      .clk(clk), .rst_n(rst_n), .stat_i(stat), .mask_i(mask), .irq_o(irq_o)
   );

   always_comb begin
      rdata = '0;
      if (rd_en && in_map) begin
         unique case (sel)
            SEL_STAT: rdata = stat;
            SEL_MASK: rdata = mask;
            default:  rdata = '0;   // write-only registers read zero
         endcase
      end
   end

   a_r3_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !(in_map && (sel == SEL_STAT || sel == SEL_MASK))) |-> (rdata == '0));

   a_r10_mask_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_map && sel == SEL_MASK) |=> $stable(mask));

   a_r9_reset_clear: assert property (@(posedge clk)
      !rst_n |-> (mask == '0 && stat == '0 && !irq_o));
endmodule

// File: tb/sim_irq_mask_bank.sv
module sim_irq_mask_bank;
   localparam int N = 3;
   localparam int AW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [N-1:0] wdata = '0, evt = '0;
   logic [N-1:0] rdata;
   logic irq;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   irq_mask_bank #(.N_SRC(N), .AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .evt_i(evt), .irq_o(irq)
   );

   // {wr, addr[2:0], wdata[2:0], evt[2:0], exp_status[2:0], exp_mask[2:0]}
   localparam int NV = 14;
   localparam logic [15:0] VEC [NV] = '{
      {1'b1, 3'd2, 3'b101, 3'b000, 3'b000, 3'b101},  // R1 enable
      {1'b0, 3'd0, 3'b000, 3'b010, 3'b010, 3'b101},  // R5 event, masked off
      {1'b0, 3'd0, 3'b000, 3'b001, 3'b011, 3'b101},  // R5 event, masked on
      {1'b1, 3'd2, 3'b010, 3'b000, 3'b011, 3'b111},  // R1 enable more
      {1'b1, 3'd3, 3'b100, 3'b000, 3'b011, 3'b011},  // R2 disable
      {1'b1, 3'd0, 3'b001, 3'b000, 3'b010, 3'b011},  // R6 clear one
      {1'b1, 3'd0, 3'b010, 3'b010, 3'b010, 3'b011},  // R7 event beats clear
      {1'b1, 3'd1, 3'b100, 3'b000, 3'b010, 3'b011},  // R10 mask write ignored
      {1'b1, 3'd2, 3'b000, 3'b000, 3'b010, 3'b011},  // R1 zero write
      {1'b1, 3'd0, 3'b000, 3'b000, 3'b010, 3'b011},  // R6 zero write
      {1'b1, 3'd3, 3'b011, 3'b000, 3'b010, 3'b000},  // R2 disable two
      {1'b0, 3'd0, 3'b000, 3'b100, 3'b110, 3'b000},  // R5 event, all masked
      {1'b1, 3'd0, 3'b110, 3'b000, 3'b000, 3'b000},  // R6 clear two
      {1'b1, 3'd2, 3'b100, 3'b000, 3'b000, 3'b100}   // R1 enable
   };
   localparam string TAG [NV] = '{"R1", "R5", "R5", "R1", "R2", "R6", "R7",
                                  "R10", "R1", "R6", "R2", "R5", "R6", "R1"};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
      rd_en = 1'b1; addr = a; #1; d = rdata; rd_en = 1'b0; #1;
   endtask

   // drive at negedge, cross one edge, return at the next negedge
   task automatic step(input logic w, input logic [AW-1:0] a,
                       input logic [N-1:0] d, input logic [N-1:0] e);
      wr_en = w; addr = a; wdata = d; evt = e;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0; wdata = '0; evt = '0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] r;
      logic [N-1:0] ps = '0, pm = '0;

      // R9: reset state
      repeat (2) @(negedge clk);
      rd(3'd0, r); chk("R9 status in reset", r, 0);
      rd(3'd1, r); chk("R9 mask in reset", r, 0);
      chk("R9 irq in reset", irq, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][15], VEC[i][14:12], VEC[i][11:9], VEC[i][8:6]);
         rd(3'd0, r); chk({TAG[i], " status"}, r, VEC[i][5:3]);
         rd(3'd1, r); chk({TAG[i], " mask"}, r, VEC[i][2:0]);
         chk("R8 irq lags state", irq, |(ps & pm));
         ps = VEC[i][5:3];
         pm = VEC[i][2:0];
      end

      // R3: write-only and unmapped reads return zero (mask now 100)
      rd(3'd2, r); chk("R3 enable reg reads 0", r, 0);
      rd(3'd3, r); chk("R3 disable reg reads 0", r, 0);
      rd(3'd5, r); chk("R3 unmapped reads 0", r, 0);
      rd(3'd1, r); chk("R4 mask readback", r, 3'b100);

      // R8: rise two edges after the event, fall two edges after the clear
      step(1'b0, 3'd0, 3'b000, 3'b100);
      chk("R8 irq low after first edge", irq, 0);
      step(1'b0, 3'd0, 3'b000, 3'b000);
      chk("R8 irq high after second edge", irq, 1);
      step(1'b1, 3'd0, 3'b100, 3'b000);
      chk("R8 irq still high after clear edge", irq, 1);
      step(1'b0, 3'd0, 3'b000, 3'b000);
      chk("R8 irq low after clear", irq, 0);

      // R9: reset in mid-run with mask and status set
      step(1'b0, 3'd0, 3'b000, 3'b100);
      step(1'b0, 3'd0, 3'b000, 3'b000);
      chk("R8 irq before reset", irq, 1);
      rst_n = 1'b0; #1;
      rd(3'd0, r); chk("R9 status cleared", r, 0);
      rd(3'd1, r); chk("R9 mask cleared", r, 0);
      chk("R9 irq cleared", irq, 0);
      @(negedge clk); rst_n = 1'b1; @(negedge clk);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule